// File: doc/BRIEF.md
# Memory block signature checker

This block folds a run of 16-bit words into a single signature, so a long stretch of target memory can be confirmed with one comparison rather than word by word. A start pulse seeds the signature register from a start address and latches the word count and the check mode. Each accepted word then advances the register by one shift-and-feedback step. When every word has been taken, the block waits for the signature that the target itself computed and reports whether the two agree.

Words arrive on a valid/ready stream. `word_ready_o` is high only while the programmed count has not yet been reached. A word transfers in a clock where `word_valid_i` and `word_ready_o` are both high. The source may hold `word_valid_i` low for any number of cycles, and a held word waits for ready. In blank-check mode the block uses an all-ones word in place of the data it accepts, so the stream still paces the count. The target signature is a plain strobe, taken only while `ready_cmp_o` is high.

Top module: `blk_sig_check`

## Requirements
- R1: After reset, `sig_o` is 0 and `word_ready_o`, `ready_cmp_o`, `done_o` and `match_o` are all low.
- R2: In the clock after `start_i`, `sig_o` equals `seed_addr_i` minus 2, taken modulo 2^16. For example, a seed of 0x0001 gives 0xFFFF.
- R3: For an accepted word, when bit 15 of the register is 1, the register is XORed with 0x0805, shifted left by one with bit 0 set to 1, and then XORed with the word. For example, 0x8000 with word 0x0000 gives 0x100B.
- R4: For an accepted word, when bit 15 of the register is 0, the register is shifted left by one, with 0 entering bit 0, and then XORed with the word. For example, 0x0001 with word 0x00F0 gives 0x00F2.
- R5: When `erase_mode_i` is 1 at start, every step uses 0xFFFF in place of the word, and `word_data_i` has no effect on the signature.
- R6: `word_ready_o` is high only while fewer than `len_i` words have been accepted. A word offered while it is low leaves `sig_o` unchanged.
- R7: `ready_cmp_o` rises once `len_i` words have been accepted. With a length of zero it rises in the clock after start, and the seed value is what gets compared.
- R8: In the clock after `ref_valid_i` is seen with `ready_cmp_o` high, `done_o` pulses for one cycle. `match_o` is 1 exactly when `ref_sig_i` equals `sig_o`, and it holds that value until the next start.
- R9: `ref_valid_i` while `ready_cmp_o` is low has no effect: no done pulse follows, and `match_o` does not change.
- R10: `start_i` takes priority over all other inputs. It clears `done_o` and `match_o` and restarts the run, even in the middle of a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Seed the register and begin a run |
| seed_addr_i | input | 16 | Start address used to form the seed |
| len_i | input | LEN_W | Number of words in the run |
| erase_mode_i | input | 1 | 1 selects blank check, using an all-ones word |
| word_valid_i | input | 1 | A word is offered |
| word_ready_o | output | 1 | The block can accept a word |
| word_data_i | input | 16 | Offered word |
| ref_valid_i | input | 1 | Target signature strobe |
| ref_sig_i | input | 16 | Signature computed by the target |
| ready_cmp_o | output | 1 | All words taken, waiting for the target signature |
| done_o | output | 1 | One-cycle pulse marking that the comparison is complete |
| match_o | output | 1 | The comparison found the signatures equal |
| sig_o | output | 16 | Current signature register |

## Verification
On every cycle, the assertions check the seeding after start, that the signature holds while no word transfers, that word ready and compare ready are never high together, and the timing of the done pulse, together with the clearing and holding of the match flag. Only the bench's scenarios can show that the feedback arithmetic is correct. They compare the final signature against an independent model, using seeds that drive both branches of the step, blank-check runs with varied data, zero-length runs, gapped streams and restarts in the middle of a run.

// File: rtl/sigchk_pkg.sv
package sigchk_pkg;
  localparam int unsigned DEF_W = 16;
  localparam logic [DEF_W-1:0] DEF_POLY = 16'h0805;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_COLLECT = 2'd1,
    PH_AWAIT   = 2'd2
  } phase_e;
endpackage

// File: rtl/sigchk_ctrl.sv
module sigchk_ctrl
  import sigchk_pkg::*;
#(
  parameter int unsigned LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             accept_i,
  input  logic             ref_fire_i,
  output logic             word_ready_o,
  output logic             cmp_ready_o
);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  phase_e           phase_q;
  logic [LEN_W-1:0] count_q;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] count_inc;

  assign count_inc = count_q + ONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      count_q <= '0;
      len_q   <= '0;
    end else if (start_i) begin
      count_q <= '0;
      len_q   <= len_i;
      phase_q <= (len_i == '0) ? PH_AWAIT : PH_COLLECT;
    end else begin
      unique case (phase_q)
        PH_COLLECT: begin
          if (accept_i) begin
            count_q <= count_inc;
            if (count_inc == len_q) phase_q <= PH_AWAIT;
          end
        end
        PH_AWAIT: begin
          if (ref_fire_i) phase_q <= PH_IDLE;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign word_ready_o = (phase_q == PH_COLLECT);
  assign cmp_ready_o  = (phase_q == PH_AWAIT);
endmodule

// File: rtl/sigchk_shreg.sv
module sigchk_shreg #(
  parameter int unsigned    W    = 16,
  parameter logic [W-1:0]   POLY = 16'h0805
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [W-1:0] seed_addr_i,
  input  logic         erase_mode_i,
  input  logic         accept_i,
  input  logic [W-1:0] word_i,
  output logic [W-1:0] sig_o
);
  localparam logic [W-1:0] SEED_OFS  = W'(2);
  localparam logic [W-1:0] BLANK_WRD = '1;

  logic [W-1:0] sig_q;
  logic         erase_q;
  logic [W-1:0] mixed;
  logic [W-1:0] stepped;
  logic [W-1:0] operand;

  always_comb begin
    mixed = sig_q ^ POLY;
    if (sig_q[W-1]) stepped = {mixed[W-2:0], 1'b1};
    else            stepped = {sig_q[W-2:0], 1'b0};
    operand = erase_q ? BLANK_WRD : word_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sig_q   <= '0;
      erase_q <= 1'b0;
    end else if (start_i) begin
      sig_q   <= seed_addr_i - SEED_OFS;
      erase_q <= erase_mode_i;
    end else if (accept_i) begin
      sig_q   <= stepped ^ operand;
    end
  end

  assign sig_o = sig_q;
endmodule

// File: rtl/sigchk_result.sv
module sigchk_result #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         ref_fire_i,
  input  logic [W-1:0] ref_sig_i,
  input  logic [W-1:0] sig_i,
  output logic         done_o,
  output logic         match_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o  <= 1'b0;
      match_o <= 1'b0;
    end else if (start_i) begin
      done_o  <= 1'b0;
      match_o <= 1'b0;
    end else begin
      done_o <= ref_fire_i;
      if (ref_fire_i) match_o <= (ref_sig_i == sig_i);
    end
  end
endmodule

// File: rtl/blk_sig_check.sv
module blk_sig_check
  import sigchk_pkg::*;
#(
  parameter int unsigned  W     = DEF_W,
  parameter logic [W-1:0] POLY  = DEF_POLY,
  parameter int unsigned  LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [W-1:0]     seed_addr_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             erase_mode_i,
  input  logic             word_valid_i,
  output logic             word_ready_o,
  input  logic [W-1:0]     word_data_i,
  input  logic             ref_valid_i,
  input  logic [W-1:0]     ref_sig_i,
  output logic             ready_cmp_o,
  output logic             done_o,
  output logic             match_o,
  output logic [W-1:0]     sig_o
);
  logic accept;
  logic ref_fire;

  assign accept   = word_valid_i & word_ready_o;
  assign ref_fire = ref_valid_i & ready_cmp_o;

  sigchk_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .len_i       (len_i),
    .accept_i    (accept),
    .ref_fire_i  (ref_fire),
    .word_ready_o(word_ready_o),
    .cmp_ready_o (ready_cmp_o)
  );

  sigchk_shreg #(.W(W), .POLY(POLY)) u_shreg (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .seed_addr_i (seed_addr_i),
    .erase_mode_i(erase_mode_i),
    .accept_i    (accept),
    .word_i      (word_data_i),
    .sig_o       (sig_o)
  );

  sigchk_result #(.W(W)) u_result (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .ref_fire_i(ref_fire),
    .ref_sig_i (ref_sig_i),
    .sig_i     (sig_o),
    .done_o    (done_o),
    .match_o   (match_o)
  );
endmodule

// File: rtl/sigchk_checker.sv
module sigchk_checker #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start_i,
  input logic [W-1:0] seed_addr_i,
  input logic         word_valid_i,
  input logic         word_ready_o,
  input logic         ref_valid_i,
  input logic         ready_cmp_o,
  input logic         done_o,
  input logic         match_o,
  input logic [W-1:0] sig_o
);
  p_seed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (sig_o == W'($past(seed_addr_i) - W'(2))));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && !(word_valid_i && word_ready_o)) |=> $stable(sig_o));

  p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(word_ready_o && ready_cmp_o));

  p_done_after_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && ref_valid_i && ready_cmp_o) |=> done_o);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_match_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && !(ref_valid_i && ready_cmp_o)) |=> $stable(match_o));

  p_no_ref_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && !ready_cmp_o) |=> !done_o);

  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (!done_o && !match_o));
endmodule

bind blk_sig_check sigchk_checker #(.W(W)) u_chk (.*);

// File: tb/test_blk_sig_check.sv
module test_blk_sig_check;
  localparam int W = 16;
  localparam int LW = 12;
  localparam time CLK_T = 8ns;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [W-1:0]  seed_addr_i = '0;
  logic [LW-1:0] len_i = '0;
  logic          erase_mode_i = 1'b0;
  logic          word_valid_i = 1'b0;
  logic          word_ready_o;
  logic [W-1:0]  word_data_i = '0;
  logic          ref_valid_i = 1'b0;
  logic [W-1:0]  ref_sig_i = '0;
  logic          ready_cmp_o;
  logic          done_o;
  logic          match_o;
  logic [W-1:0]  sig_o;

  int checks = 0;
  int fails = 0;

  typedef struct packed { logic [W-1:0] sig; logic match; } exp_t;
  exp_t sb_q[$];

  always #(CLK_T/2) clk = ~clk;

  blk_sig_check #(.LEN_W(LW)) i_blk_sig_check (.*);

  task automatic check(input logic ok, input string tag, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] model_step(input logic [W-1:0] s, input logic [W-1:0] w);
    logic [W-1:0] t;
    if (s[15]) t = (((s ^ 16'h0805) << 1) | 16'h0001);
    else       t = s << 1;
    return t ^ w;
  endfunction

  function automatic logic [W-1:0] word_of(input logic [W-1:0] seed, input int i);
    return (seed * 16'h0101) ^ (16'h1357 * i[15:0]) ^ 16'h8421;
  endfunction

  // Scoreboard monitor: each done pulse pops one expected result (R8)
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R8 unexpected done", 16'(done_o), 16'h0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(match_o == e.match, "R8 match", 16'(match_o), 16'(e.match));
        check(sig_o == e.sig, "R8 sig at done", sig_o, e.sig);
      end
    end
  end

  task automatic pulse_start(input logic [W-1:0] seed, input int n, input logic er);
    seed_addr_i  = seed;
    len_i        = LW'(n);
    erase_mode_i = er;
    start_i      = 1'b1;
    @(negedge clk);
    start_i      = 1'b0;
  endtask

  task automatic run_case(input logic [W-1:0] seed, input int n, input logic er,
                          input logic good, input logic gaps, input string tag);
    logic [W-1:0] exp_sig;
    exp_sig = seed - 16'd2;
    for (int i = 0; i < n; i++)
      exp_sig = model_step(exp_sig, er ? 16'hFFFF : word_of(seed, i));
    sb_q.push_back('{sig: exp_sig, match: good});
    pulse_start(seed, n, er);
    for (int i = 0; i < n; i++) begin
      if (gaps && (i % 2 == 1)) begin
        word_valid_i = 1'b0;
        @(negedge clk);
      end
      word_valid_i = 1'b1;
      word_data_i  = word_of(seed, i);
      @(negedge clk);
    end
    word_valid_i = 1'b0;
    check(sig_o == exp_sig, tag, sig_o, exp_sig);
    check(ready_cmp_o == 1'b1, "R7 compare ready", 16'(ready_cmp_o), 16'h1);
    ref_sig_i   = good ? exp_sig : (exp_sig ^ 16'h0001);
    ref_valid_i = 1'b1;
    @(negedge clk);
    ref_valid_i = 1'b0;
    check(done_o == 1'b1, "R8 done pulse", 16'(done_o), 16'h1);
    @(negedge clk);
    check(done_o == 1'b0, "R8 done one cycle", 16'(done_o), 16'h0);
    check(match_o == good, "R8 match held", 16'(match_o), 16'(good));
  endtask

  initial begin
    #(CLK_T * 150000);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(sig_o == 16'h0, "R1 sig", sig_o, 16'h0);
    check({word_ready_o, ready_cmp_o, done_o, match_o} == 4'b0, "R1 flags",
          16'({word_ready_o, ready_cmp_o, done_o, match_o}), 16'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 seed wraps modulo 2^16
    pulse_start(16'h0001, 1, 1'b0);
    check(sig_o == 16'hFFFF, "R2 seed wrap", sig_o, 16'hFFFF);
    check(word_ready_o == 1'b1, "R6 ready while collecting", 16'(word_ready_o), 16'h1);

    // R10 restart mid-run; R3 single step with bit 15 set
    pulse_start(16'h8002, 1, 1'b0);
    check(sig_o == 16'h8000, "R2 seed", sig_o, 16'h8000);
    word_valid_i = 1'b1; word_data_i = 16'h0000;
    @(negedge clk);
    word_valid_i = 1'b0;
    check(sig_o == 16'h100B, "R3 feedback step", sig_o, 16'h100B);

    // R6 word offered when not ready leaves sig unchanged
    check(word_ready_o == 1'b0, "R6 ready low at count", 16'(word_ready_o), 16'h0);
    word_valid_i = 1'b1; word_data_i = 16'h5A5A;
    @(negedge clk);
    word_valid_i = 1'b0;
    check(sig_o == 16'h100B, "R6 extra word ignored", sig_o, 16'h100B);

    // R9 stray target strobe before ready is ignored
    pulse_start(16'h0003, 2, 1'b0);
    ref_valid_i = 1'b1; ref_sig_i = 16'h0001;
    @(negedge clk);
    ref_valid_i = 1'b0;
    check(done_o == 1'b0, "R9 no done", 16'(done_o), 16'h0);
    check(match_o == 1'b0, "R9 match unchanged", 16'(match_o), 16'h0);

    // R4 single step with bit 15 clear
    word_valid_i = 1'b1; word_data_i = 16'h00F0;
    @(negedge clk);
    word_valid_i = 1'b0;
    check(sig_o == 16'h00F2, "R4 plain step", sig_o, 16'h00F2);

    // R5 blank check single step
    pulse_start(16'h0003, 1, 1'b1);
    word_valid_i = 1'b1; word_data_i = 16'h1234;
    @(negedge clk);
    word_valid_i = 1'b0;
    check(sig_o == 16'hFFFD, "R5 blank step", sig_o, 16'hFFFD);

    // Full runs through the scoreboard
    run_case(16'hC000, 8,  1'b0, 1'b1, 1'b0, "R3 R4 run");
    run_case(16'h1F00, 12, 1'b0, 1'b0, 1'b1, "R4 gapped run");
    run_case(16'hF002, 10, 1'b1, 1'b1, 1'b0, "R5 blank run");
    run_case(16'hF002, 10, 1'b1, 1'b1, 1'b1, "R5 data ignored");
    run_case(16'h4444, 0,  1'b0, 1'b1, 1'b0, "R7 zero length seed");
    run_case(16'h0000, 0,  1'b0, 1'b0, 1'b0, "R7 zero length mismatch");

    // R10 start clears held match
    run_case(16'h2222, 3, 1'b0, 1'b1, 1'b0, "R3 pre-restart");
    pulse_start(16'h2222, 3, 1'b0);
    check(match_o == 1'b0, "R10 match cleared", 16'(match_o), 16'h0);
    check(done_o == 1'b0, "R10 done low", 16'(done_o), 16'h0);

    repeat (3) @(negedge clk);
    check(sb_q.size() == 0, "R8 scoreboard drained", 16'(sb_q.size()), 16'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule